// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor Core

This block is a 32-bit processor core that finishes one instruction per clock. It recognises twelve integer operations: add, add-immediate, subtract, OR-immediate, load-upper-immediate, load word, store word, logical left shift, logical right shift, set-on-less-than, jump-to-register and branch-if-equal. Its parts are:

- a program counter and the logic that picks the next program counter;
- a control decoder with no state;
- a register file with thirty-two entries;
- an ALU with a shifter;
- an immediate extender.

The core reads a word-addressed instruction memory and a word-addressed data memory. Both memories sit outside the core and have combinational read ports.

Every piece of state changes on the falling edge of `clk`: the program counter, the register file, and the data memory write, which the core asks for through `dmem_we`. The rising edge changes nothing.

An instruction the decoder does not recognise runs as a no-operation. There are no delay slots, no exceptions and no byte accesses.

Top module: `mcore_top`

## Requirements
- R1: On a falling edge where `rst_n` is low, the program counter is set to 0, so `imem_addr` reads 0. While `rst_n` is low, `dmem_we` stays 0.
- R2: The program counter, the register file and the data memory write request change only on falling edges. A rising edge leaves `imem_addr` unchanged.
- R3: After any instruction other than jr or a taken beq, `imem_addr` moves up by one word.
- R4: add, sub and addi wrap modulo 2^32. addi sign-extends its 16-bit immediate.
- R5: ori zero-extends its immediate. lui writes the immediate to bits [31:16] and clears bits [15:0].
- R6: sll and srl shift rt by the 5-bit shamt field (bits [10:6]). srl fills with zeros.
- R7: slt writes 1 when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R8: lw and sw use rs plus the sign-extended offset as the byte address. `dmem_addr` carries bits [12:2] of that address. `dmem_we` is high only for sw.
- R9: A taken beq (rs equals rt) sets the next PC to PC+4 plus the sign-extended offset shifted left by 2. A beq that is not taken falls through. No delay slot follows either case.
- R10: jr loads the program counter from rs.
- R11: Register 0 always reads as zero, and any write to it is discarded.
- R12: The core uses these encodings. The opcode sits in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11], the function code in [5:0] and the immediate in [15:0]. Register-type opcode 0 uses function codes add 0x20, sub 0x22, slt 0x2A, sll 0x00, srl 0x02 and jr 0x08. The other opcodes are addi 0x08, ori 0x0D, lui 0x0F, lw 0x23, sw 0x2B and beq 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its falling edge |
| rst_n | input | 1 | Active-low reset, sampled on the falling edge |
| imem_addr | output | IMEM_AW | Word address of the current instruction |
| imem_rdata | input | XLEN | Instruction word at `imem_addr` |
| dmem_addr | output | DMEM_AW | Word address for a load or store |
| dmem_wdata | output | XLEN | Data to store (the rt value) |
| dmem_we | output | 1 | Store request, taken on the falling edge |
| dmem_rdata | input | XLEN | Word read combinationally at `dmem_addr` |

## Verification
The bench runs a program through the corner cases.

- **Sign-extension confusion.** An ori with bit 15 set, and a store with a negative offset, both corrupt memory words if the two extension modes are swapped.
- **Shifter errors.** A right shift of a negative value would leave ones at the top if the shifter filled arithmetically.
- **Signed comparison.** A comparison of -3 with 5 gives the wrong flag if slt compares unsigned.
- **Control flow.** A not-taken branch, a taken branch, a backward-branch loop and a jr each write or skip a marker word. An offset error or a delay slot therefore leaves a wrong count or a clobbered marker.
- **Register 0.** A write to register 0 followed by a store of it must give zero.
- **Address truncation.** A store above the 2048-word range must wrap onto a low word.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

   // Opcode values, instruction bits [31:26]
   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LUI   = 6'h0F;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;

   // Function codes for the register-type opcode, bits [5:0]
   localparam logic [5:0] FN_SLL = 6'h00;
   localparam logic [5:0] FN_SRL = 6'h02;
   localparam logic [5:0] FN_JR  = 6'h08;
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // Field positions within the instruction word
   localparam int unsigned F_OP_LSB = 26;
   localparam int unsigned F_RS_LSB = 21;
   localparam int unsigned F_RT_LSB = 16;
   localparam int unsigned F_RD_LSB = 11;
   localparam int unsigned F_SH_LSB = 6;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned IMM_W = 16;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_PASSB
   } alu_op_e;

   typedef enum logic [1:0] {
      EXT_SIGN, EXT_ZERO, EXT_UPPER
   } ext_mode_e;

   // Index order follows the mux rule: input A at 0, B at 1, C at 2
   typedef enum logic [1:0] {
      NPC_SEQ, NPC_BRANCH, NPC_REG
   } npc_sel_e;

   typedef struct packed {
      logic      reg_we;
      logic      dst_is_rd;
      logic      srcb_is_imm;
      logic      mem_to_reg;
      logic      mem_we;
      logic      is_branch;
      logic      is_jr;
      alu_op_e   alu_op;
      ext_mode_e ext_mode;
   } ctrl_t;

endpackage

// File: rtl/mcore_decoder.sv
module mcore_decoder
   import mcore_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl = '0;
      case (opcode)
         OP_RTYPE: begin
            case (funct)
               FN_ADD: begin
                  ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_ADD;
               end
               FN_SUB: begin
                  ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SUB;
               end
               FN_SLT: begin
                  ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLT;
               end
               FN_SLL: begin
                  ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLL;
               end
               FN_SRL: begin
                  ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SRL;
               end
               FN_JR: ctrl.is_jr = 1'b1;
               default: ctrl = '0;
            endcase
         end
         OP_ADDI: begin
            ctrl.reg_we = 1'b1; ctrl.srcb_is_imm = 1'b1;
            ctrl.alu_op = ALU_ADD; ctrl.ext_mode = EXT_SIGN;
         end
         OP_ORI: begin
            ctrl.reg_we = 1'b1; ctrl.srcb_is_imm = 1'b1;
            ctrl.alu_op = ALU_OR; ctrl.ext_mode = EXT_ZERO;
         end
         OP_LUI: begin
            ctrl.reg_we = 1'b1; ctrl.srcb_is_imm = 1'b1;
            ctrl.alu_op = ALU_PASSB; ctrl.ext_mode = EXT_UPPER;
         end
         OP_LW: begin
            ctrl.reg_we = 1'b1; ctrl.srcb_is_imm = 1'b1; ctrl.mem_to_reg = 1'b1;
            ctrl.alu_op = ALU_ADD; ctrl.ext_mode = EXT_SIGN;
         end
         OP_SW: begin
            ctrl.mem_we = 1'b1; ctrl.srcb_is_imm = 1'b1;
            ctrl.alu_op = ALU_ADD; ctrl.ext_mode = EXT_SIGN;
         end
         OP_BEQ: begin
            ctrl.is_branch = 1'b1; ctrl.alu_op = ALU_SUB; ctrl.ext_mode = EXT_SIGN;
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
   parameter int unsigned W    = 32,
   parameter int unsigned NREG = 32,
   localparam int unsigned AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b
);

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_depth
      $error("mcore_regfile: NREG must be a power of two of at least 2");
   end

   logic [W-1:0] regs [NREG];

   // Entry 0 is never written; reads of it are forced to zero below
   always_ff @(negedge clk) begin
      if (we && waddr != '0) regs[waddr] <= wdata;
   end

   assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
   assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/mcore_extend.sv
module mcore_extend
   import mcore_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [IMM_W-1:0] imm,
   input  ext_mode_e        mode,
   output logic [W-1:0]     y
);

   if (W < 2 * IMM_W) begin : g_bad_width
      $error("mcore_extend: W must be at least twice the immediate width");
   end

   always_comb begin
      case (mode)
         EXT_ZERO:  y = {{(W-IMM_W){1'b0}}, imm};
         EXT_UPPER: y = {{(W-2*IMM_W){1'b0}}, imm, {IMM_W{1'b0}}};
         default:   y = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
      endcase
   end

endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
   import mcore_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter bit          LOG_SHIFTER = 1'b1,
   localparam int unsigned SHW       = $clog2(W)
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic [SHW-1:0] shamt,
   input  alu_op_e        op,
   output logic [W-1:0]   y,
   output logic           zero
);

   if ((1 << SHW) != W) begin : g_bad_width
      $error("mcore_alu: W must be a power of two");
   end

   logic [W-1:0] sl, sr;

   if (LOG_SHIFTER) begin : g_log_shift
      // Staged network: stage s moves by 2**s when shamt bit s is set
      always_comb begin
         sl = b;
         sr = b;
         for (int s = 0; s < int'(SHW); s++) begin
            if (shamt[s]) begin
               sl = sl << (1 << s);
               sr = sr >> (1 << s);
            end
         end
      end
   end else begin : g_flat_shift
      assign sl = b << shamt;
      assign sr = b >> shamt;
   end

   logic [W-1:0] diff;
   assign diff = a - b;

   always_comb begin
      case (op)
         ALU_ADD:   y = a + b;
         ALU_SUB:   y = diff;
         ALU_OR:    y = a | b;
         ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_SLL:   y = sl;
         ALU_SRL:   y = sr;
         ALU_PASSB: y = b;
         default:   y = '0;
      endcase
   end

   assign zero = (diff == '0);

endmodule

// File: rtl/mcore_top.sv
module mcore_top
   import mcore_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned NREG        = 32,
   parameter int unsigned IMEM_AW     = 10,
   parameter int unsigned DMEM_AW     = 11,
   parameter bit          LOG_SHIFTER = 1'b1,
   parameter logic [31:0] RESET_PC    = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [IMEM_AW-1:0] imem_addr,
   input  logic [XLEN-1:0]    imem_rdata,
   output logic [DMEM_AW-1:0] dmem_addr,
   output logic [XLEN-1:0]    dmem_wdata,
   output logic               dmem_we,
   input  logic [XLEN-1:0]    dmem_rdata
);

   localparam int unsigned RAW   = $clog2(NREG);
   localparam int unsigned SHW   = $clog2(XLEN);
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcore_top: instruction format fixes XLEN at 32");
   end
   if (NREG != 32 || RAW != REG_IDX_W) begin : g_bad_nreg
      $error("mcore_top: register fields are 5 bits, NREG must be 32");
   end
   if (IMEM_AW + 2 > XLEN || DMEM_AW + 2 > XLEN) begin : g_bad_aw
      $error("mcore_top: memory address widths exceed the word");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("mcore_top: RESET_PC must be word aligned");
   end

   // Instruction fields
   logic [5:0]       f_op, f_fn;
   logic [RAW-1:0]   f_rs, f_rt, f_rd;
   logic [SHW-1:0]   f_sh;
   logic [IMM_W-1:0] f_imm;

   assign f_op  = imem_rdata[F_OP_LSB +: 6];
   assign f_rs  = imem_rdata[F_RS_LSB +: RAW];
   assign f_rt  = imem_rdata[F_RT_LSB +: RAW];
   assign f_rd  = imem_rdata[F_RD_LSB +: RAW];
   assign f_sh  = imem_rdata[F_SH_LSB +: SHW];
   assign f_fn  = imem_rdata[5:0];
   assign f_imm = imem_rdata[IMM_W-1:0];

   ctrl_t ctrl;
   mcore_decoder u_dec (
      .opcode (f_op),
      .funct  (f_fn),
      .ctrl   (ctrl)
   );

   // Register file
   logic [XLEN-1:0] rs_data, rt_data, wb_data;
   logic [RAW-1:0]  wb_idx;
   logic            rf_we;

   assign wb_idx = ctrl.dst_is_rd ? f_rd : f_rt;
   assign rf_we  = ctrl.reg_we & rst_n;

   mcore_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .we      (rf_we),
      .waddr   (wb_idx),
      .wdata   (wb_data),
      .raddr_a (f_rs),
      .raddr_b (f_rt),
      .rdata_a (rs_data),
      .rdata_b (rt_data)
   );

   // Operand path
   logic [XLEN-1:0] ext_imm, alu_b, alu_y;
   logic            alu_zero;

   mcore_extend #(.W(XLEN)) u_ext (
      .imm  (f_imm),
      .mode (ctrl.ext_mode),
      .y    (ext_imm)
   );

   assign alu_b = ctrl.srcb_is_imm ? ext_imm : rt_data;

   mcore_alu #(.W(XLEN), .LOG_SHIFTER(LOG_SHIFTER)) u_alu (
      .a     (rs_data),
      .b     (alu_b),
      .shamt (f_sh),
      .op    (ctrl.alu_op),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

   // Data memory port
   assign dmem_addr  = alu_y[DMEM_AW+1:2];
   assign dmem_wdata = rt_data;
   assign dmem_we    = ctrl.mem_we & rst_n;

   // Program counter and next-PC selection
   logic [XLEN-1:0] pc_q, pc_seq, pc_br, pc_next;
   npc_sel_e        npc_sel;

   assign pc_seq = pc_q + PC_STEP;
   assign pc_br  = pc_seq + {ext_imm[XLEN-3:0], 2'b00};

   always_comb begin
      if (ctrl.is_jr)                      npc_sel = NPC_REG;
      else if (ctrl.is_branch && alu_zero) npc_sel = NPC_BRANCH;
      else                                 npc_sel = NPC_SEQ;
   end

   always_comb begin
      case (npc_sel)
         NPC_BRANCH: pc_next = pc_br;
         NPC_REG:    pc_next = rs_data;
         default:    pc_next = pc_seq;
      endcase
   end

   always_ff @(negedge clk) begin
      if (!rst_n) pc_q <= XLEN'(RESET_PC);
      else        pc_q <= pc_next;
   end

   assign imem_addr = pc_q[IMEM_AW+1:2];

endmodule

// File: rtl/mcore_checker.sv
module mcore_checker
   import mcore_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned IMEM_AW  = 10,
   parameter int unsigned DMEM_AW  = 11,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [IMEM_AW-1:0] imem_addr,
   input logic [XLEN-1:0]    imem_rdata,
   input logic [DMEM_AW-1:0] dmem_addr,
   input logic               dmem_we,
   input logic [XLEN-1:0]    rs_data,
   input logic [XLEN-1:0]    rt_data
);

   logic               is_beq, is_jr, br_taken;
   logic [IMEM_AW-1:0] br_word, seq_word;
   logic [XLEN-1:0]    eff_addr;

   assign is_beq   = imem_rdata[31:26] == OP_BEQ;
   assign is_jr    = imem_rdata[31:26] == OP_RTYPE && imem_rdata[5:0] == FN_JR;
   assign br_taken = is_beq && (rs_data == rt_data);
   assign seq_word = imem_addr + IMEM_AW'(1);
   assign br_word  = seq_word + IMEM_AW'($signed(imem_rdata[15:0]));
   assign eff_addr = rs_data + {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

   // R1: first active edge after reset starts from the reset address
   assert_reset_pc_R1: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> imem_addr == RESET_PC[IMEM_AW+1:2]);

   // R3: ordinary instructions step one word
   assert_seq_step_R3: assert property (@(negedge clk) disable iff (!rst_n)
      (!br_taken && !is_jr) |=> imem_addr == $past(seq_word));

   // R9: taken branch reaches the offset target
   assert_branch_target_R9: assert property (@(negedge clk) disable iff (!rst_n)
      br_taken |=> imem_addr == $past(br_word));

   // R10: register jump loads rs
   assert_jr_target_R10: assert property (@(negedge clk) disable iff (!rst_n)
      is_jr |=> imem_addr == $past(rs_data[IMEM_AW+1:2]));

   // R8: a store goes to the word of rs plus sign-extended offset
   assert_store_addr_R8: assert property (@(negedge clk) disable iff (!rst_n)
      dmem_we |-> (imem_rdata[31:26] == OP_SW && dmem_addr == eff_addr[DMEM_AW+1:2]));

   // R11: register 0 always reads as zero on both ports
   assert_zero_reg_R11: assert property (@(negedge clk) disable iff (!rst_n)
      (imem_rdata[25:21] == '0 |-> rs_data == '0) and (imem_rdata[20:16] == '0 |-> rt_data == '0));

endmodule

bind mcore_top mcore_checker #(
   .XLEN(XLEN), .IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW), .RESET_PC(RESET_PC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .imem_addr  (imem_addr),
   .imem_rdata (imem_rdata),
   .dmem_addr  (dmem_addr),
   .dmem_we    (dmem_we),
   .rs_data    (rs_data),
   .rt_data    (rt_data)
);

// File: tb/mcore_top_tb_top.sv
`timescale 1ns/1ps
module mcore_top_tb_top;

   localparam int unsigned IAW = 10;
   localparam int unsigned DAW = 11;
   localparam int N_EXP = 18;
   localparam logic [31:0] MARK = 32'hDEADBEEF;
   localparam int HALT_WORD = 43;

   // Expected data-memory contents after the program halts
   localparam logic [DAW-1:0] EXP_ADDR [N_EXP] = '{
      11'd0, 11'd1, 11'd2, 11'd3, 11'd4, 11'd5, 11'd6, 11'd7, 11'd8,
      11'd9, 11'd10, 11'd11, 11'd12, 11'd13, 11'd14, 11'd15, 11'd16, 11'd18};
   localparam logic [31:0] EXP_VAL [N_EXP] = '{
      32'h2, 32'hFFFFFFF8, 32'h00008001, 32'h1234ABCD, 32'h234ABCD0, 32'hF,
      32'h1, 32'h0, 32'h0, 32'h5, 32'h0, 32'h1234ABCD, 32'h5, MARK, 32'h3,
      MARK, 32'd164, 32'h5};

   function automatic string exp_req(input int i);
      case (i)
         0, 1:      return "R4 add/sub/addi";
         2, 3:      return "R5 ori/lui";
         4, 5:      return "R6 sll/srl";
         6, 7:      return "R7 slt";
         8:         return "R11 r0 write ignored";
         9, 10, 11: return "R8 lw/sw offset";
         12, 13, 14: return "R9 beq";
         15, 16:    return "R10 jr";
         default:   return "R8 address bits [12:2]";
      endcase
   endfunction

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [IAW-1:0] imem_addr;
   logic [31:0]    imem_rdata;
   logic [DAW-1:0] dmem_addr;
   logic [31:0]    dmem_wdata;
   logic           dmem_we;
   logic [31:0]    dmem_rdata;

   logic [31:0] imem [1 << IAW];
   logic [31:0] dmem [1 << DAW];

   int n_total = 0;
   int n_bad   = 0;

   always #2 clk = ~clk;

   assign imem_rdata = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];
   always @(negedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

   mcore_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                         input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_program();
      for (int i = 0; i < (1 << IAW); i++) imem[i] = 32'h0;
      for (int i = 0; i < (1 << DAW); i++) dmem[i] = 32'h0;
      dmem[8]  = MARK;
      dmem[13] = MARK;
      dmem[15] = MARK;
      imem[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);           // addi r1 = 5
      imem[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);        // addi r2 = -3
      imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20);      // add r3
      imem[3]  = enc_r(5'd2, 5'd1, 5'd4, 5'd0, 6'h22);      // sub r4 = r2-r1
      imem[4]  = enc_i(6'h0D, 5'd0, 5'd5, 16'h8001);        // ori r5
      imem[5]  = enc_i(6'h0F, 5'd0, 5'd6, 16'h1234);        // lui r6
      imem[6]  = enc_i(6'h0D, 5'd6, 5'd6, 16'hABCD);        // ori r6
      imem[7]  = enc_r(5'd0, 5'd6, 5'd7, 5'd4, 6'h00);      // sll r7
      imem[8]  = enc_r(5'd0, 5'd2, 5'd8, 5'd28, 6'h02);     // srl r8
      imem[9]  = enc_r(5'd2, 5'd1, 5'd9, 5'd0, 6'h2A);      // slt r9
      imem[10] = enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h2A);     // slt r10
      for (int k = 0; k < 8; k++)                           // sw r3..r10 to words 0..7
         imem[11+k] = enc_i(6'h2B, 5'd0, 5'(3+k), 16'(4*k));
      imem[19] = enc_i(6'h08, 5'd0, 5'd0, 16'd77);          // addi r0 (discarded)
      imem[20] = enc_i(6'h2B, 5'd0, 5'd0, 16'd32);          // sw r0 -> word 8
      imem[21] = enc_i(6'h08, 5'd0, 5'd11, 16'd40);         // r11 = 40
      imem[22] = enc_i(6'h2B, 5'd11, 5'd1, 16'hFFFC);       // sw r1, -4(r11) -> word 9
      imem[23] = enc_i(6'h23, 5'd0, 5'd12, 16'd12);         // lw r12 <- word 3
      imem[24] = enc_i(6'h2B, 5'd11, 5'd12, 16'd4);         // sw r12 -> word 11
      imem[25] = enc_i(6'h04, 5'd1, 5'd2, 16'd1);           // beq not taken
      imem[26] = enc_i(6'h2B, 5'd0, 5'd1, 16'd48);          // sw -> word 12
      imem[27] = enc_i(6'h04, 5'd1, 5'd1, 16'd1);           // beq taken, skip 28
      imem[28] = enc_i(6'h2B, 5'd0, 5'd1, 16'd52);          // skipped
      imem[29] = enc_i(6'h08, 5'd0, 5'd13, 16'd3);          // r13 = 3
      imem[30] = enc_i(6'h08, 5'd0, 5'd14, 16'd0);          // r14 = 0
      imem[31] = enc_i(6'h08, 5'd14, 5'd14, 16'd1);         // loop: r14++
      imem[32] = enc_i(6'h08, 5'd13, 5'd13, 16'hFFFF);      // r13--
      imem[33] = enc_i(6'h04, 5'd13, 5'd0, 16'd1);          // exit when zero
      imem[34] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFC);        // back to 31
      imem[35] = enc_i(6'h2B, 5'd0, 5'd14, 16'd56);         // sw r14 -> word 14
      imem[36] = enc_i(6'h08, 5'd0, 5'd15, 16'd164);        // r15 = byte 164
      imem[37] = enc_r(5'd15, 5'd0, 5'd0, 5'd0, 6'h08);     // jr r15
      for (int k = 38; k <= 40; k++)                        // skipped by jr
         imem[k] = enc_i(6'h2B, 5'd0, 5'd1, 16'd60);
      imem[41] = enc_i(6'h2B, 5'd0, 5'd15, 16'd64);         // sw r15 -> word 16
      imem[42] = enc_i(6'h2B, 5'd0, 5'd1, 16'h2048);        // wraps to word 18
      imem[43] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);        // self loop
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
   endtask

   initial begin : watchdog
      #800000;
      n_total++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : main
      logic [IAW-1:0] held;
      load_program();
      repeat (3) @(negedge clk);
      @(posedge clk); #1;
      check("R1 reset pc", 32'(imem_addr), 32'h0);
      check("R1 no store in reset", 32'(dmem_we), 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      held = imem_addr;
      check("R3 first step", 32'(imem_addr), 32'h1);
      @(posedge clk); #1;
      check("R2 rising edge holds pc", 32'(imem_addr), 32'(held));
      @(negedge clk); #1;
      check("R2 falling edge advances", 32'(imem_addr), 32'h2);

      repeat (150) @(negedge clk);
      @(posedge clk); #1;
      check("R9 backward self-loop halt", 32'(imem_addr), 32'(HALT_WORD));
      check("R8 no store when not sw", 32'(dmem_we), 32'h0);

      for (int i = 0; i < N_EXP; i++)
         check(exp_req(i), dmem[EXP_ADDR[i]], EXP_VAL[i]);

      // Reset in mid-run returns to address 0
      rst_n = 1'b0;
      @(negedge clk); #1;
      check("R1 reset mid-run", 32'(imem_addr), 32'h0);
      @(negedge clk); #1;
      check("R1 held in reset", 32'(imem_addr), 32'h0);
      check("R12 decode under reset no store", 32'(dmem_we), 32'h0);

      summary();
      $finish;
   end

endmodule